// File: doc/BRIEF.md
# SCL Clock Waveform Generator

This block times the serial clock of an I2C master. A single configuration word sets three fields: a power-of-two exponent, a mantissa for the low half-period and a mantissa for the high half-period. Each half-period lasts the mantissa shifted left by the exponent, plus a fixed offset, in cycles of the peripheral clock. The symmetric bus rate is therefore Fclk / (2 x (mantissa x 2^exponent + offset)). Software computes the mantissas; a typical setting targets 100 kHz, and 400 kHz is the upper limit.

The bit engine raises an enable. While the enable is high, the generator alternates between a low phase, in which it pulls SCL down, and a high phase, in which it releases the line. It pulses a strobe on the first cycle of each phase so that the bit engine can change SDA and sample it. In the high phase the count advances only on cycles in which SCL is sensed high. A slave that holds the line low therefore stretches the clock. The configuration word is sampled once per bit, when the low phase starts. When the enable is low, the line stays released.

Top module: `scl_wavegen`

## Requirements
- R1: During and after reset, with the enable low, `scl_pull_o`, `low_start_o` and `high_start_o` are all 0.
- R2: The low phase keeps `scl_pull_o` at 1 for exactly L x 2^E + CLK_OFFSET cycles. L is bits [7:0] of the configuration word and E is bits [18:16].
- R3: With no stretching, the high phase keeps `scl_pull_o` at 0 for exactly H x 2^E + CLK_OFFSET cycles, where H is bits [15:8].
- R4: An exponent field above MAX_EXP is treated as MAX_EXP in both phases.
- R5: The high-phase count holds on every cycle in which `scl_sense_i` is 0. Each such cycle lengthens the high phase by one cycle.
- R6: The configuration word is sampled on the cycle a low phase begins. A change made during a bit does not affect that bit's low or high phase, and it takes effect from the next low phase.
- R7: `low_start_o` is 1 only on the first cycle of each low phase, and `high_start_o` is 1 only on the first cycle of each high phase. The two are never 1 together.
- R8: If the enable is low when a high phase completes, the generator goes idle and keeps the line released. Dropping the enable earlier does not shorten the bit in progress.
- R9: With the enable held high, a new low phase starts on the cycle right after the high count completes, with no idle cycle between them.
- R10: A mantissa of zero gives a half-period of exactly CLK_OFFSET cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en_i | input | 1 | Run request from the bit engine |
| cfg_word_i | input | 2*DIV_W+EXP_W (19) | Exponent [18:16], high mantissa [15:8], low mantissa [7:0] |
| scl_sense_i | input | 1 | Synchronized level of the SCL line |
| scl_pull_o | output | 1 | 1 = drive SCL low, 0 = release |
| low_start_o | output | 1 | Pulse on the first cycle of a low phase |
| high_start_o | output | 1 | Pulse on the first cycle of a high phase |

## Verification
Two decisions can fall due in the same cycle. When the high count completes, the generator must choose between starting the next low phase and going idle. It also decides whether a stretched cycle counts. The bench holds SCL low for a chosen number of cycles from the start of the high phase. It checks that the next low strobe arrives exactly that many cycles late, with no idle cycle in between. It then drops the enable during the following low phase. It checks that this bit runs to its full length and that no further low phase or strobe appears. All of this runs across a sweep of exponents, including values above the exponent limit, and of small mantissas.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

endpackage

// File: rtl/scl_span_calc.sv
// Converts a mantissa/exponent pair into a terminal count (span - 1).
module scl_span_calc #(
    parameter int DIV_W      = 8,
    parameter int EXP_W      = 3,
    parameter int MAX_EXP    = 7,
    parameter int CLK_OFFSET = 4,
    parameter int CNT_W      = 15
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic [CNT_W-1:0] span_m1_o
);
    localparam int EXP_CEIL = (1 << EXP_W) - 1;

    logic [EXP_W-1:0] exp_eff;

    generate
        if (MAX_EXP >= EXP_CEIL) begin : g_no_clamp
            assign exp_eff = exp_i;
        end else begin : g_clamp
            assign exp_eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;
        end
    endgenerate

    always_comb begin
        span_m1_o = (CNT_W'(div_i) << exp_eff) + CNT_W'(CLK_OFFSET - 1);
    end

endmodule

// File: rtl/scl_tick_ctr.sv
// Loadable down counter with a hold input.
module scl_tick_ctr #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
    parameter int DIV_W      = 8,
    parameter int EXP_W      = 3,
    parameter int MAX_EXP    = 7,
    parameter int CLK_OFFSET = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     gen_en_i,
    input  logic [2*DIV_W+EXP_W-1:0] cfg_word_i,
    input  logic                     scl_sense_i,
    output logic                     scl_pull_o,
    output logic                     low_start_o,
    output logic                     high_start_o
);
    import scl_wavegen_pkg::*;

    localparam int CFG_W    = 2*DIV_W + EXP_W;
    localparam int EXP_LSB  = 2*DIV_W;
    localparam int HI_LSB   = DIV_W;
    localparam int MAX_SPAN = ((1 << DIV_W) - 1) * (1 << MAX_EXP) + CLK_OFFSET;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);
    localparam int N_LANES  = 2;   // lane 0: low phase, lane 1: high phase

    typedef struct packed {
        scl_phase_e       phase;
        logic [DIV_W-1:0] hdiv;
        logic [EXP_W-1:0] expo;
        logic             low_stb;
        logic             high_stb;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [DIV_W-1:0] cfg_ldiv, cfg_hdiv;
    logic [EXP_W-1:0] cfg_exp;

    assign cfg_ldiv = cfg_word_i[DIV_W-1:0];
    assign cfg_hdiv = cfg_word_i[HI_LSB +: DIV_W];
    assign cfg_exp  = cfg_word_i[EXP_LSB +: EXP_W];

    logic [DIV_W-1:0] lane_div  [N_LANES];
    logic [EXP_W-1:0] lane_exp  [N_LANES];
    logic [CNT_W-1:0] lane_span [N_LANES];

    // The low span comes straight from the word so the phase can start on
    // the sampling cycle; the high span uses the copy latched at that cycle.
    assign lane_div[0] = cfg_ldiv;
    assign lane_exp[0] = cfg_exp;
    assign lane_div[1] = st_q.hdiv;
    assign lane_exp[1] = st_q.expo;

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            scl_span_calc #(
                .DIV_W     (DIV_W),
                .EXP_W     (EXP_W),
                .MAX_EXP   (MAX_EXP),
                .CLK_OFFSET(CLK_OFFSET),
                .CNT_W     (CNT_W)
            ) u_span (
                .div_i    (lane_div[g]),
                .exp_i    (lane_exp[g]),
                .span_m1_o(lane_span[g])
            );
        end
    endgenerate

    logic             ctr_load, ctr_dec, ctr_zero;
    logic [CNT_W-1:0] ctr_load_val, cnt_val;

    scl_tick_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ctr_load),
        .load_val_i(ctr_load_val),
        .dec_i     (ctr_dec),
        .cnt_o     (cnt_val),
        .zero_o    (ctr_zero)
    );

    always_comb begin
        st_d          = st_q;
        st_d.low_stb  = 1'b0;
        st_d.high_stb = 1'b0;
        ctr_load      = 1'b0;
        ctr_load_val  = lane_span[0];
        ctr_dec       = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (gen_en_i) begin
                    st_d.phase   = PH_LOW;
                    st_d.hdiv    = cfg_hdiv;
                    st_d.expo    = cfg_exp;
                    st_d.low_stb = 1'b1;
                    ctr_load     = 1'b1;
                end
            end
            PH_LOW: begin
                if (ctr_zero) begin
                    st_d.phase    = PH_HIGH;
                    st_d.high_stb = 1'b1;
                    ctr_load      = 1'b1;
                    ctr_load_val  = lane_span[1];
                end else begin
                    ctr_dec = 1'b1;
                end
            end
            PH_HIGH: begin
                if (scl_sense_i) begin
                    if (!ctr_zero) begin
                        ctr_dec = 1'b1;
                    end else if (gen_en_i) begin
                        st_d.phase   = PH_LOW;
                        st_d.hdiv    = cfg_hdiv;
                        st_d.expo    = cfg_exp;
                        st_d.low_stb = 1'b1;
                        ctr_load     = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, hdiv: '0, expo: '0, low_stb: 1'b0, high_stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_pull_o   = (st_q.phase == PH_LOW);
    assign low_start_o  = st_q.low_stb;
    assign high_start_o = st_q.high_stb;

endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
    parameter int CNT_W = 15
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         gen_en_i,
    input logic                         scl_sense_i,
    input logic                         scl_pull_o,
    input logic                         low_start_o,
    input logic                         high_start_o,
    input scl_wavegen_pkg::scl_phase_e  phase,
    input logic [CNT_W-1:0]             cnt
);
    import scl_wavegen_pkg::*;

    p_idle_stays_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en_i && !scl_pull_o) |=> !scl_pull_o);

    p_low_strobe_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_start_o |-> scl_pull_o);

    p_high_strobe_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        high_start_o |-> !scl_pull_o);

    p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start_o, high_start_o}));

    p_pull_rise_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_o) |-> low_start_o);

    p_pull_fall_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull_o) |-> high_start_o);

    p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH && !scl_sense_i) |=> $stable(cnt));

    p_no_restart_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !gen_en_i) |=> !low_start_o);

endmodule

bind scl_wavegen scl_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_en_i    (gen_en_i),
    .scl_sense_i (scl_sense_i),
    .scl_pull_o  (scl_pull_o),
    .low_start_o (low_start_o),
    .high_start_o(high_start_o),
    .phase       (st_q.phase),
    .cnt         (cnt_val)
);

// File: tb/scl_wavegen_tb.sv
module scl_wavegen_tb;

    localparam int DIV_W   = 8;
    localparam int EXP_W   = 3;
    localparam int MAX_EXP = 5;
    localparam int OFS     = 3;
    localparam int CFG_W   = 2*DIV_W + EXP_W;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             en    = 1'b0;
    logic             hold  = 1'b0;
    logic [CFG_W-1:0] cfg   = '0;
    logic             pull, lstb, hstb;
    logic             sense;

    assign sense = !pull && !hold;   // wired-AND line with a stretching slave

    always #10 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    scl_wavegen #(
        .DIV_W     (DIV_W),
        .EXP_W     (EXP_W),
        .MAX_EXP   (MAX_EXP),
        .CLK_OFFSET(OFS)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_en_i    (en),
        .cfg_word_i  (cfg),
        .scl_sense_i (sense),
        .scl_pull_o  (pull),
        .low_start_o (lstb),
        .high_start_o(hstb)
    );

    function automatic int span(int e, int d);
        int ee = (e > MAX_EXP) ? MAX_EXP : e;
        return d * (1 << ee) + OFS;
    endfunction

    function automatic logic [CFG_W-1:0] pack(int e, int h, int l);
        return {3'(e), 8'(h), 8'(l)};
    endfunction

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Entry: current sample is the first low cycle.
    task automatic measure_low(output int len, output int bad);
        len = 0;
        bad = 0;
        while (pull === 1'b1 && len < 20000) begin
            if (len > 0 && lstb) bad++;
            if (hstb) bad++;
            len++;
            @(negedge clk);
        end
    endtask

    // Entry: current sample is the first high cycle. Holds SCL for k cycles.
    task automatic measure_high(int k, output int len, output int bad);
        len = 0;
        bad = 0;
        while (pull === 1'b0 && len < 20000) begin
            hold = (len < k);
            if (len > 0 && hstb) bad++;
            if (lstb) bad++;
            len++;
            @(negedge clk);
        end
        hold = 1'b0;
    endtask

    task automatic run_case(int e1, int l1, int h1, int e2, int l2, int h2, int k);
        int len, bad, seen;
        @(negedge clk);
        cfg = pack(e1, h1, l1);
        en  = 1'b1;
        @(negedge clk);
        chk("R7 low strobe on first low cycle", int'(lstb), 1);
        cfg = pack(e2, h2, l2);          // R6: mid-bit change
        measure_low(len, bad);
        chk("R2 low phase length", len, span(e1, l1));
        if (l1 == 0) chk("R10 zero low mantissa", len, OFS);
        if (e1 > MAX_EXP) chk("R4 clamped exponent low", len, span(MAX_EXP, l1));
        chk("R7 single strobe in low phase", bad, 0);
        chk("R7 high strobe on first high cycle", int'(hstb), 1);
        measure_high(k, len, bad);
        if (k > 0) chk("R5 stretched high length", len, span(e1, h1) + k);
        else       chk("R3 high phase length", len, span(e1, h1));
        chk("R6 high uses word sampled at low start", len - k, span(e1, h1));
        chk("R7 single strobe in high phase", bad, 0);
        chk("R9 back-to-back low strobe", int'(lstb), 1);
        en = 1'b0;
        measure_low(len, bad);
        chk("R6 next low uses new word", len, span(e2, l2));
        chk("R8 disabled bit keeps full low", bad, 0);
        seen = 0;
        for (int i = 0; i < span(e2, h2) + 8; i++) begin
            if (pull || lstb) seen++;
            @(negedge clk);
        end
        chk("R8 idle and released after disable", seen, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pull low in reset", int'(pull), 0);
        chk("R1 strobes low in reset", int'(lstb | hstb), 0);
        rst_n = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (pull || lstb || hstb) seen++;
            end
            chk("R1 released while disabled", seen, 0);
        end

        for (int e = 0; e < 8; e++) begin
            for (int l = 0; l < 4; l++) begin
                for (int h = 0; h < 4; h++) begin
                    run_case(e, l, h, (e + 3) % 8, 3 - l, h ^ 1, (l + h) % 3);
                end
            end
        end
        run_case(5, 255, 255, 0, 0, 0, 0);
        run_case(7, 255, 254, 6, 1, 2, 0);
        run_case(2, 1, 2, 1, 1, 1, 40);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule